// File: doc/BRIEF.md
# Address Window Chip Select Decoder

This block turns a 24-bit physical access address into one chip select. Software sets up four address windows through a simple register write port. Each window holds an enable bit, a 4-bit size code and a 12-bit start field that stands for address bits 23 down to 12, so the finest window is 4 kByte. The size code says how large the window is. Address bits inside the window are not compared, and the start-field bits at those positions are ignored. The address bits above the window size must equal the corresponding start-field bits.

An access is offered by raising `acc_valid` with `acc_addr`. One cycle later the block raises `cs_valid` and exactly one select. That select is either the line of the lowest-numbered window that matched, or the default select when no enabled window matched. Bus timing, wait states and bus-control settings belong to other logic. This block only decides which select is asserted.

Top module: `addr_window_cs`

## Requirements
- R1: After reset every window is disabled. While reset is held and on the cycle after it, `cs_valid`, `cs_win` and `cs_dflt` are all 0.
- R2: The outputs are registered. The cycle after `acc_valid` is high, `cs_valid` is 1. The cycle after `acc_valid` is low, `cs_valid`, `cs_win` and `cs_dflt` are all 0.
- R3: A window with size code c (0 to 11) covers 2^(12+c) bytes. A hit requires that address bits A23..A(12+c) equal start bits [11:c]. Start bits [c-1:0] and address bits below A(12+c) take no part in the comparison.
- R4: Size code 0101 gives a 128 kByte window. Only A23..A17 are compared, so with start 0x3E0 the addresses 0x3E0000 through 0x3FFFFF hit and 0x3DFFFF and 0x400000 do not.
- R5: Size codes 1100 through 1111 behave like 1011 (8 MByte): only A23 is compared.
- R6: Bit i of `cs_win` is the select of the window written with `cfg_idx` = i. Index 0 drives chip select 1 and index 3 drives chip select 4.
- R7: When several enabled windows match, only the lowest-index one is asserted.
- R8: A valid access that matches no enabled window asserts `cs_dflt` and leaves `cs_win` at 0. A disabled window (`cfg_en` = 0) never matches.
- R9: For every valid access exactly one of the five selects (`cs_win` bits and `cs_dflt`) is 1.
- R10: A register write in cycle t is used by accesses presented in cycle t+1 and later. An access presented in the same cycle as the write is decoded with the old settings.
- R11: When `cfg_we` is 1, the window chosen by `cfg_idx` loads `cfg_en`, `cfg_size` and `cfg_start` together at the clock edge, and the other windows keep their settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_idx | input | 2 | Window index being written (0..3 = chip select 1..4) |
| cfg_en | input | 1 | Enable bit for the written window |
| cfg_size | input | 4 | Size code for the written window |
| cfg_start | input | 12 | Start field (A23..A12) for the written window |
| acc_valid | input | 1 | Access address strobe |
| acc_addr | input | 24 | Access address |
| cs_valid | output | 1 | Registered: a decoded access is on the select lines |
| cs_win | output | 4 | Registered one-hot window selects, bit 0 = chip select 1 |
| cs_dflt | output | 1 | Registered default select (chip select 0) |

## Verification
The bench probes addresses one byte either side of each window edge for the 4 kByte, 128 kByte, 256 kByte and clamped 8 MByte sizes. If the mask were off by one bit, one of those neighbours would land on the wrong select. It programs a start field with nonzero low bits inside a 256 kByte window; a design that failed to mask those bits would drop the window to the default select. It sets up overlapping windows to catch a design that asserts two selects or lets a higher index win. It also issues an access in the same cycle as a reconfiguring write, which catches a design that forwards the new settings one cycle early. A long randomized run against an independent model then covers code and address mixes that the directed cases miss.

// File: rtl/awcs_pkg.sv
package awcs_pkg;
  // Default geometry shared by the decoder and its checker
  localparam int unsigned AWCS_ADDR_W  = 24;
  localparam int unsigned AWCS_GRAN_W  = 12;  // 4 kByte granule
  localparam int unsigned AWCS_NUM_WIN = 4;
  localparam int unsigned AWCS_SIZE_W  = 4;
endpackage

// File: rtl/awcs_cfg_regs.sv
module awcs_cfg_regs #(
  parameter int unsigned NUM_WIN = awcs_pkg::AWCS_NUM_WIN,
  parameter int unsigned SIZE_W  = awcs_pkg::AWCS_SIZE_W,
  parameter int unsigned FIELD_W = 12,
  localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  logic [IDX_W-1:0]                 idx,
  input  logic                             en_in,
  input  logic [SIZE_W-1:0]                size_in,
  input  logic [FIELD_W-1:0]               start_in,
  output logic [NUM_WIN-1:0]               win_en,
  output logic [NUM_WIN-1:0][SIZE_W-1:0]   win_size,
  output logic [NUM_WIN-1:0][FIELD_W-1:0]  win_start
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic sel;
    assign sel = we && (idx == IDX_W'(w));
    always_ff @(posedge clk) begin
      if (rst) begin
        win_en[w]    <= 1'b0;
        win_size[w]  <= '0;
        win_start[w] <= '0;
      end else if (sel) begin
        win_en[w]    <= en_in;
        win_size[w]  <= size_in;
        win_start[w] <= start_in;
      end
    end
  end
endmodule

// File: rtl/awcs_win_match.sv
module awcs_win_match #(
  parameter int unsigned SIZE_W  = awcs_pkg::AWCS_SIZE_W,
  parameter int unsigned FIELD_W = 12,
  localparam int unsigned MAX_CODE = FIELD_W - 1
) (
  input  logic               en,
  input  logic [SIZE_W-1:0]  size,
  input  logic [FIELD_W-1:0] start,
  input  logic [FIELD_W-1:0] addr_hi,
  output logic               hit
);
  logic [SIZE_W-1:0]  code_eff;
  logic [FIELD_W-1:0] cmp_mask;

  // Codes beyond the largest window clamp to it
  always_comb begin
    if (int'(size) > MAX_CODE) code_eff = SIZE_W'(MAX_CODE);
    else                       code_eff = size;
  end

  // Field bits at or above the code position take part in the compare
  always_comb begin
    for (int j = 0; j < FIELD_W; j++) begin
      cmp_mask[j] = (j >= int'(code_eff));
    end
  end

  assign hit = en && (((addr_hi ^ start) & cmp_mask) == '0);
endmodule

// File: rtl/awcs_prio.sv
module awcs_prio #(
  parameter int unsigned NUM_WIN = awcs_pkg::AWCS_NUM_WIN
) (
  input  logic [NUM_WIN-1:0] hits,
  output logic [NUM_WIN-1:0] pick,
  output logic               any
);
  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (hits[w] && !any) begin
        pick[w] = 1'b1;
        any     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/addr_window_cs.sv
module addr_window_cs #(
  parameter int unsigned ADDR_W  = awcs_pkg::AWCS_ADDR_W,
  parameter int unsigned GRAN_W  = awcs_pkg::AWCS_GRAN_W,
  parameter int unsigned NUM_WIN = awcs_pkg::AWCS_NUM_WIN,
  parameter int unsigned SIZE_W  = awcs_pkg::AWCS_SIZE_W,
  localparam int unsigned FIELD_W = ADDR_W - GRAN_W,
  localparam int unsigned IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_en,
  input  logic [SIZE_W-1:0]  cfg_size,
  input  logic [FIELD_W-1:0] cfg_start,
  input  logic               acc_valid,
  input  logic [ADDR_W-1:0]  acc_addr,
  output logic               cs_valid,
  output logic [NUM_WIN-1:0] cs_win,
  output logic               cs_dflt
);
  logic [NUM_WIN-1:0]              win_en;
  logic [NUM_WIN-1:0][SIZE_W-1:0]  win_size;
  logic [NUM_WIN-1:0][FIELD_W-1:0] win_start;
  logic [NUM_WIN-1:0]              hits;
  logic [NUM_WIN-1:0]              pick;
  logic                            any_hit;
  logic [FIELD_W-1:0]              addr_hi;

  assign addr_hi = acc_addr[ADDR_W-1:GRAN_W];

  awcs_cfg_regs #(
    .NUM_WIN (NUM_WIN),
    .SIZE_W  (SIZE_W),
    .FIELD_W (FIELD_W)
  ) regs_i (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .idx       (cfg_idx),
    .en_in     (cfg_en),
    .size_in   (cfg_size),
    .start_in  (cfg_start),
    .win_en    (win_en),
    .win_size  (win_size),
    .win_start (win_start)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    awcs_win_match #(
      .SIZE_W  (SIZE_W),
      .FIELD_W (FIELD_W)
    ) match_i (
      .en      (win_en[w]),
      .size    (win_size[w]),
      .start   (win_start[w]),
      .addr_hi (addr_hi),
      .hit     (hits[w])
    );
  end

  awcs_prio #(.NUM_WIN(NUM_WIN)) prio_i (
    .hits (hits),
    .pick (pick),
    .any  (any_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_valid <= 1'b0;
      cs_win   <= '0;
      cs_dflt  <= 1'b0;
    end else begin
      cs_valid <= acc_valid;
      cs_win   <= acc_valid ? pick : '0;
      cs_dflt  <= acc_valid && !any_hit;
    end
  end
endmodule

// File: rtl/awcs_chk.sv
module awcs_chk #(
  parameter int unsigned NUM_WIN = awcs_pkg::AWCS_NUM_WIN
) (
  input logic               clk,
  input logic               rst,
  input logic               acc_valid,
  input logic               cs_valid,
  input logic [NUM_WIN-1:0] cs_win,
  input logic               cs_dflt
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!cs_valid && cs_win == '0 && !cs_dflt));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> cs_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!cs_valid && cs_win == '0 && !cs_dflt));

  // R9
  one_select_chk: assert property (@(posedge clk) disable iff (rst)
    cs_valid |-> ($countones({cs_win, cs_dflt}) == 1));

  // R7
  win_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_win));

  // R8
  dflt_excl_chk: assert property (@(posedge clk) disable iff (rst)
    cs_dflt |-> (cs_win == '0 && cs_valid));
endmodule

bind addr_window_cs awcs_chk #(.NUM_WIN(NUM_WIN)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .acc_valid (acc_valid),
  .cs_valid  (cs_valid),
  .cs_win    (cs_win),
  .cs_dflt   (cs_dflt)
);

// File: tb/addr_window_cs_tb_top.sv
module addr_window_cs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic        cfg_en = 1'b0;
  logic [3:0]  cfg_size = '0;
  logic [11:0] cfg_start = '0;
  logic        acc_valid = 1'b0;
  logic [23:0] acc_addr = '0;
  logic        cs_valid;
  logic [3:0]  cs_win;
  logic        cs_dflt;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  addr_window_cs dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_size(cfg_size), .cfg_start(cfg_start), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .cs_valid(cs_valid), .cs_win(cs_win), .cs_dflt(cs_dflt)
  );

  typedef struct {
    logic       vld;
    logic [3:0] win;
    logic       dflt;
    string      tag;
  } exp_t;

  exp_t q[$];

  // Shadow of the window settings, kept from the requirements
  logic        sh_en[4];
  logic [3:0]  sh_size[4];
  logic [11:0] sh_start[4];

  function automatic exp_t model(input logic v, input logic [23:0] a, input string tag);
    exp_t e;
    e.vld = v; e.win = '0; e.dflt = 1'b0; e.tag = tag;
    if (v) begin
      for (int w = 0; w < 4; w++) begin
        int c;
        c = (sh_size[w] > 4'd11) ? 11 : int'(sh_size[w]);
        if (e.win == '0 && sh_en[w] &&
            ((int'(a) >> (12 + c)) == (int'(sh_start[w]) >> c)))
          e.win[w] = 1'b1;
      end
      e.dflt = (e.win == '0);
    end
    return e;
  endfunction

  task automatic access(input logic v, input logic [23:0] a, input string tag);
    @(negedge clk);
    cfg_we = 1'b0;
    acc_valid = v;
    acc_addr = a;
    q.push_back(model(v, a, tag));
  endtask

  task automatic cfg_write(input logic [1:0] idx, input logic en, input logic [3:0] sz,
                           input logic [11:0] st, input logic v, input logic [23:0] a,
                           input string tag);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_en = en; cfg_size = sz; cfg_start = st;
    acc_valid = v; acc_addr = a;
    q.push_back(model(v, a, tag));  // same-cycle access sees old settings (R10)
    sh_en[idx] = en; sh_size[idx] = sz; sh_start[idx] = st;
  endtask

  // Monitor: outputs settle after the edge that registered the access
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (cs_valid !== e.vld || cs_win !== e.win || cs_dflt !== e.dflt) begin
          bad++;
          $display("FAIL %s: got vld=%b win=%b dflt=%b expected vld=%b win=%b dflt=%b",
                   e.tag, cs_valid, cs_win, cs_dflt, e.vld, e.win, e.dflt);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < 4; w++) begin
      sh_en[w] = 1'b0; sh_size[w] = '0; sh_start[w] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: outputs zero while reset is held
    total++;
    if (cs_valid !== 1'b0 || cs_win !== 4'b0 || cs_dflt !== 1'b0) begin
      bad++;
      $display("FAIL R1: got vld=%b win=%b dflt=%b expected 0 0000 0", cs_valid, cs_win, cs_dflt);
    end
    rst = 1'b0;
    access(1'b1, 24'h123456, "R1 all windows disabled -> default");
    access(1'b0, 24'h000000, "R2 idle cycle quiet");

    // R4 128 kByte window on chip select 1
    cfg_write(2'd0, 1'b1, 4'b0101, 12'h3E0, 1'b0, 24'h0, "R11 write idle");
    access(1'b1, 24'h3E0000, "R4 low edge hit");
    access(1'b1, 24'h3FFFFF, "R4 high edge hit");
    access(1'b1, 24'h3DFFFF, "R4 below miss");
    access(1'b1, 24'h400000, "R4 above miss");

    // R3 4 kByte window on chip select 2
    cfg_write(2'd1, 1'b1, 4'd0, 12'h200, 1'b0, 24'h0, "R11 write idle");
    access(1'b1, 24'h200000, "R3 4k low edge");
    access(1'b1, 24'h200FFF, "R3 4k high edge");
    access(1'b1, 24'h201000, "R3 4k above miss");

    // R3 256 kByte window, start low bits nonzero (ignored)
    cfg_write(2'd2, 1'b1, 4'd6, 12'h103, 1'b0, 24'h0, "R11 write idle");
    access(1'b1, 24'h100000, "R3 256k base with masked start bits");
    access(1'b1, 24'h13FFFF, "R3 256k top");
    access(1'b1, 24'h140000, "R3 256k above miss");
    access(1'b1, 24'h0FFFFF, "R3 256k below miss");

    // R7 overlapping 8 MByte window on chip select 4
    cfg_write(2'd3, 1'b1, 4'd11, 12'h000, 1'b0, 24'h0, "R11 write idle");
    access(1'b1, 24'h3E0010, "R7 window1 beats window4");
    access(1'b1, 24'h200800, "R7 window2 beats window4");
    access(1'b1, 24'h120000, "R7 window3 beats window4");
    access(1'b1, 24'h000010, "R6 only window4 -> bit3");
    access(1'b1, 24'h800000, "R8 upper half miss");

    // R5 clamped size code
    cfg_write(2'd3, 1'b1, 4'd15, 12'h800, 1'b0, 24'h0, "R11 write idle");
    access(1'b1, 24'hFFFFFF, "R5 clamped code top");
    access(1'b1, 24'h800000, "R5 clamped code base");
    access(1'b1, 24'h7FFFFF, "R5 lower half -> default");

    // R10 write and access in the same cycle
    cfg_write(2'd0, 1'b0, 4'b0101, 12'h3E0, 1'b1, 24'h3E0004, "R10 same-cycle uses old");
    access(1'b1, 24'h3E0004, "R10 next cycle disabled -> default R8");
    access(1'b0, 24'h3E0004, "R2 valid low quiet");

    // Randomized sweep against the model
    for (int i = 0; i < 600; i++) begin
      logic [11:0] lo;
      logic [1:0]  pw;
      logic [23:0] a;
      lo = 12'($urandom);
      pw = 2'($urandom);
      a = ($urandom % 2 == 0) ? {sh_start[pw], lo} ^ 24'($urandom % 4096 << ($urandom % 12))
                              : 24'($urandom);
      if (i % 9 == 0)
        cfg_write(2'($urandom), 1'($urandom), 4'($urandom), 12'($urandom),
                  1'($urandom), a, "R10 R11 random write");
      else
        access(($urandom % 5) != 0, a, "R3 R7 R9 random access");
    end

    access(1'b0, 24'h0, "R2 final idle");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule